// File: doc/BRIEF.md
# Fault-Hardened Cipher Round Counter

This block keeps track of the rounds of an iterated block cipher and guards the count against fault injection. A start pulse loads a total round count that depends on the key-length code. Each accepted advance pulse then moves two counters at once: one counts executed rounds up from zero, and the other counts remaining rounds down from the total. A parity bit is stored with the up-counter. Every cycle, the block checks that the two counters add up to the stored total and that the stored parity matches the up-counter. Any mismatch moves the block into a terminal fault state. It leaves that state only on reset.

The controller around the block reads the executed-round number, a flag for the last regular round and a completion flag. It treats the alert output as a security event. A test port can flip one bit of the up-counter, the down-counter or the parity register at the next clock edge. This lets a bench, or a production self-test, prove that the detection works. Reset is synchronous and active high. The status outputs are decoded from registered state.

Top module: `rc_guarded_round_ctr`

## Requirements
- R1: A start pulse accepted with `key_len_i` = 0 loads a total of 10 rounds. Code 1 loads 12, and codes 2 and 3 both load 14. Completion follows after exactly that many accepted advance pulses.
- R2: An accepted start sets `round_o` to 0 at the next edge. Each advance pulse accepted while running raises `round_o` by exactly one at the next edge.
- R3: The remaining count falls by one on each accepted advance. The edge at which it reaches zero ends the run and sets `done_o`. `done_o` stays high until the next accepted start and is never high together with `alert_o`.
- R4: `last_o` is high only while running and while `round_o` equals the total minus one.
- R5: Advance pulses have no effect while idle, complete or faulted. A start pulse has no effect while a run is in progress or while faulted.
- R6: If the executed count plus the remaining count, taken modulo 16, differs from the stored total, `alert_o` is high from the next edge.
- R7: If the XOR of the executed-count bits differs from the stored parity bit, `alert_o` is high from the next edge.
- R8: Once `alert_o` is high, it stays high and `round_o` is frozen until reset, whatever the counters later hold. Start and advance are ignored in this state, and `done_o` stays low.
- R9: While `rst` is high at a clock edge, the counters, the parity bit and the total are cleared to zero. At that edge `round_o` becomes 0, and `last_o`, `done_o` and `alert_o` become low.
- R10: When `fault_en_i` is high, the edge inverts bit `fault_bit_i` of one register, chosen by `fault_tgt_i`. Code 0 selects the up-counter, 1 the down-counter and 2 the parity bit (the bit index is not used for parity). Code 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load a new round count |
| key_len_i | input | 2 | Key-length code: 0 gives 10 rounds, 1 gives 12, 2 and 3 give 14 |
| advance_i | input | 1 | Complete one round |
| fault_en_i | input | 1 | Apply a test bit flip at this edge |
| fault_tgt_i | input | 2 | Flip target: 0 up-counter, 1 down-counter, 2 parity, 3 none |
| fault_bit_i | input | 2 | Bit index of the flip within a counter |
| round_o | output | 4 | Executed-round count |
| last_o | output | 1 | Last regular round in progress |
| done_o | output | 1 | Run completed without fault |
| alert_o | output | 1 | Sticky fault alert |

## Verification
A random phase mixes start and advance pulses with every key-length code. It covers restarts after completion, advances ignored while idle or complete, and starts ignored mid-run. It separates a correct round total from an off-by-one total and a correct `last_o` position from a shifted one. Directed fault flips target each register in turn. A down-counter flip breaks only the sum check, a parity flip breaks only the parity check, and an up-counter flip breaks both, so each detector is shown to work on its own. After an alert, further start and advance pulses confirm the alert is sticky and the count is frozen, and the no-effect flip code confirms that no false alert appears.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } rc_state_e;

  typedef enum logic [1:0] {
    FT_UP   = 2'd0,
    FT_DOWN = 2'd1,
    FT_PAR  = 2'd2,
    FT_NONE = 2'd3
  } rc_fault_tgt_e;

endpackage

// File: rtl/rc_total_sel.sv
module rc_total_sel #(
  parameter int CNT_W       = 4,
  parameter int ROUNDS_K128 = 10,
  parameter int ROUNDS_K192 = 12,
  parameter int ROUNDS_K256 = 14
) (
  input  logic [1:0]       key_len,
  output logic [CNT_W-1:0] total
);

  always_comb begin
    unique case (key_len)
      2'd0:    total = CNT_W'(ROUNDS_K128);
      2'd1:    total = CNT_W'(ROUNDS_K192);
      default: total = CNT_W'(ROUNDS_K256);
    endcase
  end

endmodule

// File: rtl/rc_dual_count.sv
module rc_dual_count
  import rc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int BIT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             fault_en,
  input  logic [1:0]       fault_tgt,
  input  logic [BIT_W-1:0] fault_bit,
  output logic [CNT_W-1:0] up_q,
  output logic [CNT_W-1:0] dn_q,
  output logic             par_q,
  output logic [CNT_W-1:0] tot_q
);

  logic [CNT_W-1:0] up_n, dn_n, tot_n;
  logic [CNT_W-1:0] flip_vec;
  logic             flip_up, flip_dn, flip_par;

  // Test flip decode: one-hot bit mask within the selected counter
  always_comb begin
    flip_vec = '0;
    flip_vec[fault_bit] = 1'b1;
    flip_up  = fault_en && (rc_fault_tgt_e'(fault_tgt) == FT_UP);
    flip_dn  = fault_en && (rc_fault_tgt_e'(fault_tgt) == FT_DOWN);
    flip_par = fault_en && (rc_fault_tgt_e'(fault_tgt) == FT_PAR);
  end

  // Functional next values before any test flip
  always_comb begin
    up_n  = up_q;
    dn_n  = dn_q;
    tot_n = tot_q;
    if (load) begin
      up_n  = '0;
      dn_n  = load_val;
      tot_n = load_val;
    end else if (step) begin
      up_n = up_q + CNT_W'(1);
      dn_n = dn_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q  <= '0;
      dn_q  <= '0;
      par_q <= 1'b0;
      tot_q <= '0;
    end else begin
      up_q  <= up_n ^ (flip_up ? flip_vec : '0);
      dn_q  <= dn_n ^ (flip_dn ? flip_vec : '0);
      par_q <= (^up_n) ^ flip_par;
      tot_q <= tot_n;
    end
  end

endmodule

// File: rtl/rc_integrity.sv
module rc_integrity #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] up_q,
  input  logic [CNT_W-1:0] dn_q,
  input  logic             par_q,
  input  logic [CNT_W-1:0] tot_q,
  output logic             sum_err,
  output logic             par_err
);

  logic [CNT_W-1:0] sum;

  always_comb begin
    sum     = up_q + dn_q;
    sum_err = (sum != tot_q);
    par_err = ((^up_q) != par_q);
  end

endmodule

// File: rtl/rc_guarded_round_ctr.sv
module rc_guarded_round_ctr
  import rc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int ROUNDS_K128 = 10,
  parameter int ROUNDS_K192 = 12,
  parameter int ROUNDS_K256 = 14,
  localparam int BIT_W      = (CNT_W > 1) ? $clog2(CNT_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       key_len_i,
  input  logic             advance_i,
  input  logic             fault_en_i,
  input  logic [1:0]       fault_tgt_i,
  input  logic [BIT_W-1:0] fault_bit_i,
  output logic [CNT_W-1:0] round_o,
  output logic             last_o,
  output logic             done_o,
  output logic             alert_o
);

  rc_state_e        state_q, state_d;
  logic [CNT_W-1:0] total_sel;
  logic [CNT_W-1:0] up_q, dn_q, tot_q;
  logic             par_q;
  logic             sum_err, par_err, any_err;
  logic             load, step;

  rc_total_sel #(
    .CNT_W      (CNT_W),
    .ROUNDS_K128(ROUNDS_K128),
    .ROUNDS_K192(ROUNDS_K192),
    .ROUNDS_K256(ROUNDS_K256)
  ) u_total (
    .key_len(key_len_i),
    .total  (total_sel)
  );

  rc_dual_count #(
    .CNT_W(CNT_W),
    .BIT_W(BIT_W)
  ) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (total_sel),
    .step     (step),
    .fault_en (fault_en_i),
    .fault_tgt(fault_tgt_i),
    .fault_bit(fault_bit_i),
    .up_q     (up_q),
    .dn_q     (dn_q),
    .par_q    (par_q),
    .tot_q    (tot_q)
  );

  rc_integrity #(
    .CNT_W(CNT_W)
  ) u_integ (
    .up_q   (up_q),
    .dn_q   (dn_q),
    .par_q  (par_q),
    .tot_q  (tot_q),
    .sum_err(sum_err),
    .par_err(par_err)
  );

  assign any_err = sum_err || par_err;

  // Accept commands only in states that allow them and never on a detected error
  always_comb begin
    load = start_i && !any_err &&
           (state_q == ST_IDLE || state_q == ST_DONE);
    step = advance_i && !any_err && (state_q == ST_RUN);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (load) state_d = ST_RUN;
      ST_RUN:           if (step && dn_q == CNT_W'(1)) state_d = ST_DONE;
      default:          state_d = ST_FAULT;
    endcase
    if (any_err) state_d = ST_FAULT;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign round_o = up_q;
  assign done_o  = (state_q == ST_DONE);
  assign alert_o = (state_q == ST_FAULT);
  assign last_o  = (state_q == ST_RUN) && (up_q == tot_q - CNT_W'(1));

endmodule

// File: rtl/rc_guard_chk.sv
module rc_guard_chk
  import rc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             advance_i,
  input logic             fault_en_i,
  input logic [CNT_W-1:0] round_o,
  input logic             last_o,
  input logic             done_o,
  input logic             alert_o,
  input logic [CNT_W-1:0] up_q,
  input logic [CNT_W-1:0] dn_q,
  input logic             par_q,
  input logic [CNT_W-1:0] tot_q,
  input logic [1:0]       state
);

  logic mis_sum, mis_par;
  assign mis_sum = (CNT_W'(up_q + dn_q) != tot_q);
  assign mis_par = ((^up_q) != par_q);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (round_o == '0 && !alert_o && !done_o && !last_o));

  // R8
  alert_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    alert_o |=> alert_o);

  // R8
  alert_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (alert_o && !fault_en_i) |=> $stable(round_o));

  // R6
  sum_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    mis_sum |=> alert_o);

  // R7
  parity_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    mis_par |=> alert_o);

  // R3
  done_alert_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && alert_o));

  // R4
  last_excl_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |-> (!done_o && !alert_o));

  // R5
  idle_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start_i && !fault_en_i) |=> $stable(round_o));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && advance_i && !fault_en_i && !mis_sum && !mis_par)
    |=> (round_o == CNT_W'($past(round_o) + 1)));

endmodule

bind rc_guarded_round_ctr rc_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .advance_i (advance_i),
  .fault_en_i(fault_en_i),
  .round_o   (round_o),
  .last_o    (last_o),
  .done_o    (done_o),
  .alert_o   (alert_o),
  .up_q      (up_q),
  .dn_q      (dn_q),
  .par_q     (par_q),
  .tot_q     (tot_q),
  .state     (state_q)
);

// File: tb/sim_rc_guarded_round_ctr.sv
`timescale 1ns/1ps
module sim_rc_guarded_round_ctr;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] key_len_i = 2'd0;
  logic       advance_i = 1'b0;
  logic       fault_en_i = 1'b0;
  logic [1:0] fault_tgt_i = 2'd3;
  logic [1:0] fault_bit_i = 2'd0;
  logic [3:0] round_o;
  logic       last_o, done_o, alert_o;

  int n_chk = 0;
  int n_err = 0;

  // reference state: 0 idle, 1 run, 2 done, 3 fault
  logic [3:0] m_up = '0, m_dn = '0, m_tot = '0;
  logic       m_par = 1'b0;
  int         m_st = 0;

  always #2 clk = ~clk;

  rc_guarded_round_ctr u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .key_len_i(key_len_i),
    .advance_i(advance_i), .fault_en_i(fault_en_i), .fault_tgt_i(fault_tgt_i),
    .fault_bit_i(fault_bit_i), .round_o(round_o), .last_o(last_o),
    .done_o(done_o), .alert_o(alert_o)
  );

  function automatic logic [3:0] exp_total(input logic [1:0] k);
    return (k == 2'd0) ? 4'd10 : (k == 2'd1) ? 4'd12 : 4'd14;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic       err, ld, st;
    logic [3:0] nu, nd, fm;
    err = (4'(m_up + m_dn) != m_tot) || ((^m_up) != m_par);
    if (rst) begin
      m_up = '0; m_dn = '0; m_tot = '0; m_par = 1'b0; m_st = 0;
      return;
    end
    ld = start_i && !err && (m_st == 0 || m_st == 2);
    st = advance_i && !err && (m_st == 1);
    nu = m_up; nd = m_dn;
    if (ld) begin nu = '0; nd = exp_total(key_len_i); m_tot = nd; end
    else if (st) begin nu = m_up + 4'd1; nd = m_dn - 4'd1; end
    if (err) m_st = 3;
    else if (ld) m_st = 1;
    else if (st && m_dn == 4'd1) m_st = 2;
    fm = 4'b0001 << fault_bit_i;
    m_par = (^nu) ^ (fault_en_i && fault_tgt_i == 2'd2);
    m_up = nu ^ ((fault_en_i && fault_tgt_i == 2'd0) ? fm : 4'd0);
    m_dn = nd ^ ((fault_en_i && fault_tgt_i == 2'd1) ? fm : 4'd0);
  endtask

  task automatic compare_all();
    check("R2 round", round_o, m_up);
    check("R4 last", last_o, (m_st == 1) && (m_up == 4'(m_tot - 4'd1)));
    check("R3 done", done_o, m_st == 2);
    check("R8 alert", alert_o, m_st == 3);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    start_i = 0; advance_i = 0; fault_en_i = 0; fault_tgt_i = 2'd3;
  endtask

  task automatic do_start(input logic [1:0] k);
    start_i = 1; key_len_i = k; tick(); start_i = 0;
  endtask

  task automatic do_adv(input int n);
    advance_i = 1;
    for (int i = 0; i < n; i++) tick();
    advance_i = 0;
  endtask

  task automatic do_fault(input logic [1:0] tgt, input logic [1:0] b);
    fault_en_i = 1; fault_tgt_i = tgt; fault_bit_i = b; tick();
    fault_en_i = 0; fault_tgt_i = 2'd3;
  endtask

  task automatic do_reset();
    rst = 1; idle_inputs(); tick(); tick(); rst = 0;
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    @(negedge clk);
    do_reset();
    // R9 reset state
    check("R9 round after reset", round_o, 0);
    check("R9 alert after reset", alert_o, 0);
    check("R9 done after reset", done_o, 0);

    // R5 advance while idle is ignored
    do_adv(3);
    check("R5 idle advance", round_o, 0);

    // R1 R4 every key-length code
    for (int k = 0; k < 4; k++) begin
      int n;
      n = exp_total(2'(k));
      do_start(2'(k));
      check("R2 start clears round", round_o, 0);
      do_adv(n - 1);
      check("R4 last at total-1", last_o, 1);
      check("R1 not done before total", done_o, 0);
      do_adv(1);
      check("R1 done after total", done_o, 1);
      check("R1 round equals total", round_o, n);
      do_adv(2);
      check("R5 advance after done ignored", round_o, n);
    end

    // R5 start during run ignored
    do_start(2'd0);
    do_adv(2);
    do_start(2'd2);
    check("R5 start mid-run ignored", round_o, 2);
    do_adv(8);
    check("R5 original total kept", done_o, 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      start_i   = ($urandom % 10) == 0;
      key_len_i = 2'($urandom % 4);
      advance_i = ($urandom % 10) < 6;
      tick();
    end
    idle_inputs();

    // R10 code 3 flips nothing
    do_fault(2'd3, 2'd1);
    tick(); tick();
    check("R10 no-effect code", alert_o, 0);

    // R6 down-counter flip, sum check only
    do_start(2'd1);
    do_adv(3);
    do_fault(2'd1, 2'd2);
    tick();
    check("R6 sum mismatch alert", alert_o, 1);
    // R8 sticky and frozen
    do_start(2'd0);
    do_adv(4);
    check("R8 alert sticky", alert_o, 1);
    check("R8 round frozen", round_o, 3);
    check("R8 done low", done_o, 0);
    do_reset();
    check("R9 reset clears alert", alert_o, 0);
    check("R9 reset clears round", round_o, 0);

    // R7 parity flip, parity check only
    do_start(2'd2);
    do_adv(5);
    do_fault(2'd2, 2'd0);
    tick();
    check("R7 parity mismatch alert", alert_o, 1);
    do_reset();

    // R10 up-counter flip in idle
    do_fault(2'd0, 2'd3);
    tick();
    check("R10 up flip alert", alert_o, 1);
    tick(); tick();
    check("R8 alert stays", alert_o, 1);
    do_reset();

    // R3 fault after done clears done
    do_start(2'd0);
    do_adv(10);
    check("R3 done set", done_o, 1);
    do_fault(2'd1, 2'd0);
    tick();
    check("R3 done cleared by fault", done_o, 0);
    do_reset();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule